// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller with Low-Power Handling

This block sequences a 10-bit successive-approximation conversion. Software writes a control byte that selects the input channel, the reference, the result alignment and the converter enable, and sets a busy flag to start. The block then presents a trial code to an external DAC and comparator, one bit per clock, and keeps each bit the comparator confirms. The finished code is presented as two 8-bit result bytes, in either left- or right-aligned form. A sticky completion flag is raised when the busy flag drops.

When the chip enters its low-power state, what happens depends on the conversion clock source. On the internal RC source the start is held back by a fixed number of cycles so that the sleep can be entered first. A conversion that is running then completes, and it either raises a wake pulse or powers the converter down. On any other source, entering sleep aborts the conversion at once and powers the converter down. This power-down is an internal state, so the enable bit still reads 1. A periodic trigger from a compare unit can also start a conversion, and it sends a one-cycle clear pulse to that unit's timer.

The sequencer has three states. `S_IDLE` goes to `S_DELAY` on a start with the RC source, or to `S_CONV` on a start with any other source. `S_DELAY` goes to `S_CONV` when its delay count runs out. `S_CONV` returns to `S_IDLE` after the last bit. Both busy states return to `S_IDLE` on an abort, which is a disable or a sleep on a non-RC source.

Top module: `adc_seq_ctrl`

## Requirements
- R1: `ctrl_rd` reads {align bit7, reference bit6, 0 bit5, 0 bit4, channel bits3:2, busy bit1, enable bit0}. Writes to bits 5:4 are dropped. After reset every output is 0.
- R2: A write to address 0 (`wr_addr`=0) with data bits 1 and 0 both set starts a conversion when the block is idle. On a non-RC source, busy reads 1 from the write edge until the 10th edge after it, and it reads 0 after that edge.
- R3: During a conversion, `dac_code` is the bits kept so far plus the bit under test, starting at 0x200. A `cmp_in` of 1 keeps that bit. The final code equals the analog level that the comparator sees.
- R4: With the align bit at 0, `res_hi` holds code[9:2], and `res_lo` holds code[1:0] in bits 7:6 with bits 5:0 at 0.
- R5: With the align bit at 1, `res_hi` holds code[9:8] in bits 1:0 with bits 7:2 at 0, and `res_lo` holds code[7:0].
- R6: With `clk_is_rc`=1, completion comes RC_DELAY (default 4) cycles later than in R2, which is 14 edges after the write.
- R7: A go write while the block is busy does not restart the conversion. A go write with enable 0 does not start one. If enable is cleared during a conversion, the conversion stops one edge later and leaves the results and the flag unchanged.
- R8: `done_flag` rises on the edge where busy falls at completion, and it stays at 1 until a write to address 1 clears it.
- R9: With the RC source, sleep and `irq_en` all at 1, the conversion completes and `wake` pulses for exactly one cycle as the flag rises.
- R10: With the RC source, sleep at 1 and `irq_en` at 0, the conversion completes and `conv_on` drops to 0 while the enable bit still reads 1.
- R11: With a non-RC source, if sleep is asserted during a conversion, the block is idle on the next edge, `conv_on` is 0, enable reads 1, and neither the results nor the flag change.
- R12: While the converter is powered down, `trig` is ignored. Any write to address 0 powers it up again.
- R13: `trig` with enable 1 and the converter powered starts a conversion if the block is idle, and it gives a one-cycle `timer_clr` pulse after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control byte, 1 = flag clear |
| wr_data | input | 8 | Write data |
| clk_is_rc | input | 1 | Conversion clock is the internal RC source |
| sleep_req | input | 1 | Chip is in its low-power state |
| irq_en | input | 1 | Completion interrupt enabled |
| trig | input | 1 | Periodic start trigger |
| cmp_in | input | 1 | Comparator: analog level >= dac_code |
| ctrl_rd | output | 8 | Control byte read value |
| res_hi | output | 8 | Upper result byte |
| res_lo | output | 8 | Lower result byte |
| done_flag | output | 1 | Sticky completion flag |
| dac_code | output | 10 | Trial code to the DAC |
| chan_sel | output | 2 | Analog channel select |
| ref_ext | output | 1 | External reference selected |
| conv_on | output | 1 | Converter powered |
| timer_clr | output | 1 | One-cycle timer clear pulse |
| wake | output | 1 | One-cycle wake pulse |

## Verification
The assertions assume that `sleep_req` and `clk_is_rc` are levels that stay put for whole cycles. They also assume that `trig` is sampled once per edge, and that a write to address 0 is the only way the enable bit changes. The bench drives every input on the falling edge, so none of them changes near an active edge. It changes the clock source and the alignment only while the block is idle, and it pulses `trig` for a single cycle. Its comparator is a continuous compare of a fixed analog level against `dac_code`, which gives the immediate answer the sequencer expects.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_DELAY = 2'd1,
        S_CONV  = 2'd2
    } conv_state_e;

    localparam int REG_W = 8;
endpackage

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic             cmp_in,
    output logic [RES_W-1:0] trial,
    output logic [RES_W-1:0] res_nx,
    output logic             last
);
    localparam int IDX_W = $clog2(RES_W);

    logic [RES_W-1:0] acc_q;
    logic [IDX_W-1:0] idx_q;
    logic [RES_W-1:0] bit_m;

    assign bit_m  = {{(RES_W-1){1'b0}}, 1'b1} << idx_q;
    assign trial  = acc_q | bit_m;
    assign res_nx = cmp_in ? trial : acc_q;
    assign last   = (idx_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            idx_q <= '0;
        end else if (load) begin
            acc_q <= '0;
            idx_q <= IDX_W'(RES_W - 1);
        end else if (step) begin
            acc_q <= res_nx;
            if (!last) idx_q <= idx_q - 1'b1;
        end
    end
endmodule

// File: rtl/adc_res_fmt.sv
module adc_res_fmt #(
    parameter int RES_W = 10,
    parameter int REG_W = 8
) (
    input  logic [RES_W-1:0] res,
    input  logic             right,
    output logic [REG_W-1:0] hi,
    output logic [REG_W-1:0] lo
);
    localparam int HI_W   = RES_W - REG_W;
    localparam int LO_PAD = 2 * REG_W - RES_W;

    logic [REG_W-1:0] l_hi, l_lo, r_hi, r_lo;

    assign l_hi = res[RES_W-1 -: REG_W];
    assign l_lo = {res[HI_W-1:0], {LO_PAD{1'b0}}};
    assign r_hi = {{LO_PAD{1'b0}}, res[RES_W-1:REG_W]};
    assign r_lo = res[REG_W-1:0];

    assign hi = right ? r_hi : l_hi;
    assign lo = right ? r_lo : l_lo;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W    = 10,
    parameter int RC_DELAY = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             clk_is_rc,
    input  logic             sleep_req,
    input  logic             irq_en,
    input  logic             trig,
    input  logic             cmp_in,
    output logic [7:0]       ctrl_rd,
    output logic [7:0]       res_hi,
    output logic [7:0]       res_lo,
    output logic             done_flag,
    output logic [RES_W-1:0] dac_code,
    output logic [1:0]       chan_sel,
    output logic             ref_ext,
    output logic             conv_on,
    output logic             timer_clr,
    output logic             wake
);
    localparam int DLY_W = $clog2(RC_DELAY + 1);

    conv_state_e state_q, state_nx;

    logic             en_q, fmt_q, ref_q, shut_q;
    logic [1:0]       chs_q;
    logic [DLY_W-1:0] cnt_q;
    logic [RES_W-1:0] res_q;
    logic             flag_q, tclr_q, wake_q;

    logic wr_ctrl, wr_clr, busy;
    logic start_sw, start_hw, start, sleep_abort, abort;
    logic load, step, complete, last;
    logic [RES_W-1:0] trial, res_nx;

    assign wr_ctrl     = wr_en && !wr_addr;
    assign wr_clr      = wr_en && wr_addr;
    assign busy        = (state_q != S_IDLE);
    assign start_sw    = wr_ctrl && wr_data[1] && wr_data[0];
    assign start_hw    = trig && en_q && !shut_q;
    assign start       = (state_q == S_IDLE) && (start_sw || start_hw);
    assign sleep_abort = busy && sleep_req && !clk_is_rc;
    assign abort       = busy && (!en_q || sleep_abort);
    assign step        = (state_q == S_CONV) && !abort;
    assign complete    = step && last;
    assign load        = (start && !clk_is_rc) ||
                         ((state_q == S_DELAY) && !abort && (cnt_q == '0));

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_nx = clk_is_rc ? S_DELAY : S_CONV;
            S_DELAY: if (abort) state_nx = S_IDLE;
                     else if (cnt_q == '0) state_nx = S_CONV;
            S_CONV:  if (abort || last) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_nx;
    end

    // registers and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            fmt_q  <= 1'b0;
            ref_q  <= 1'b0;
            chs_q  <= '0;
            shut_q <= 1'b0;
            cnt_q  <= '0;
            res_q  <= '0;
            flag_q <= 1'b0;
            tclr_q <= 1'b0;
            wake_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                fmt_q <= wr_data[7];
                ref_q <= wr_data[6];
                chs_q <= wr_data[3:2];
                en_q  <= wr_data[0];
            end
            if (sleep_abort || (complete && sleep_req && clk_is_rc && !irq_en))
                shut_q <= 1'b1;
            else if (wr_ctrl)
                shut_q <= 1'b0;
            if (start)
                cnt_q <= DLY_W'(RC_DELAY - 1);
            else if (state_q == S_DELAY && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
            if (complete) res_q <= res_nx;
            if (complete)    flag_q <= 1'b1;
            else if (wr_clr) flag_q <= 1'b0;
            tclr_q <= start_hw;
            wake_q <= complete && irq_en && sleep_req;
        end
    end

    adc_sar_core #(.RES_W(RES_W)) u_sar (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .step   (step),
        .cmp_in (cmp_in),
        .trial  (trial),
        .res_nx (res_nx),
        .last   (last)
    );

    adc_res_fmt #(.RES_W(RES_W), .REG_W(REG_W)) u_fmt (
        .res   (res_q),
        .right (fmt_q),
        .hi    (res_hi),
        .lo    (res_lo)
    );

    assign ctrl_rd   = {fmt_q, ref_q, 2'b00, chs_q, busy, en_q};
    assign done_flag = flag_q;
    assign dac_code  = (state_q == S_CONV) ? trial : '0;
    assign chan_sel  = chs_q;
    assign ref_ext   = ref_q;
    assign conv_on   = en_q && !shut_q;
    assign timer_clr = tclr_q;
    assign wake      = wake_q;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       wr_addr,
    input logic [7:0] wr_data,
    input logic       clk_is_rc,
    input logic       sleep_req,
    input logic       trig,
    input logic [7:0] ctrl_rd,
    input logic       done_flag,
    input logic       conv_on,
    input logic       timer_clr,
    input logic       wake
);
    // R8: the flag rises only where busy falls
    p_flag_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $fell(ctrl_rd[1]));

    // R7: a disabled converter that is not being enabled is idle on the next cycle
    p_idle_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_rd[0] && !(wr_en && !wr_addr && wr_data[0])) |=> !ctrl_rd[1]);

    // R11: sleep on a non-RC source aborts, powers down, and raises no flag
    p_abort_sleep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd[1] && sleep_req && !clk_is_rc) |=>
            (!ctrl_rd[1] && !conv_on && !$rose(done_flag)));

    // R13: a timer clear pulse follows a trigger
    p_timer_from_trig_r13: assert property (@(posedge clk) disable iff (!rst_n)
        timer_clr |-> $past(trig));

    // R9: a wake pulse comes with a set flag
    p_wake_with_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> done_flag);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .clk_is_rc (clk_is_rc),
    .sleep_req (sleep_req),
    .trig      (trig),
    .ctrl_rd   (ctrl_rd),
    .done_flag (done_flag),
    .conv_on   (conv_on),
    .timer_clr (timer_clr),
    .wake      (wake)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic       clk_is_rc = 1'b0, sleep_req = 1'b0, irq_en = 1'b0, trig = 1'b0;
    logic       cmp_in;
    logic [7:0] ctrl_rd, res_hi, res_lo;
    logic       done_flag, ref_ext, conv_on, timer_clr, wake;
    logic [9:0] dac_code;
    logic [1:0] chan_sel;
    logic [9:0] analog = '0;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    assign cmp_in = (analog >= dac_code);

    adc_seq_ctrl i_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .clk_is_rc(clk_is_rc), .sleep_req(sleep_req), .irq_en(irq_en), .trig(trig),
        .cmp_in(cmp_in), .ctrl_rd(ctrl_rd), .res_hi(res_hi), .res_lo(res_lo),
        .done_flag(done_flag), .dac_code(dac_code), .chan_sel(chan_sel),
        .ref_ext(ref_ext), .conv_on(conv_on), .timer_clr(timer_clr), .wake(wake)
    );

    // {rc, align, level[9:0], exp_hi, exp_lo}
    localparam logic [27:0] VECS [8] = '{
        {1'b0, 1'b1, 10'h2A5, 8'h02, 8'hA5},
        {1'b0, 1'b0, 10'h2A5, 8'hA9, 8'h40},
        {1'b0, 1'b1, 10'h3FF, 8'h03, 8'hFF},
        {1'b0, 1'b0, 10'h3FF, 8'hFF, 8'hC0},
        {1'b1, 1'b0, 10'h000, 8'h00, 8'h00},
        {1'b1, 1'b1, 10'h155, 8'h01, 8'h55},
        {1'b0, 1'b0, 10'h200, 8'h80, 8'h00},
        {1'b1, 1'b0, 10'h0FF, 8'h3F, 8'hC0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset ctrl", ctrl_rd, 8'h00);
        check("R1 reset hi", res_hi, 8'h00);
        check("R1 reset lo", res_lo, 8'h00);
        check("R1 reset flag/on/tclr", {done_flag, conv_on, timer_clr, wake}, 4'b0);
        rst_n = 1'b1;

        for (int i = 0; i < 8; i++) begin
            logic [27:0] v;
            int n;
            v = VECS[i];
            clk_is_rc = v[27];
            analog = v[25:16];
            n = v[27] ? 14 : 10;
            wr(1'b0, {v[26], 1'b0, 2'b00, 2'(i), 1'b1, 1'b1});
            repeat (n - 1) @(negedge clk);
            check(v[27] ? "R6 busy before end" : "R2 busy before end", ctrl_rd[1], 1'b1);
            @(negedge clk);
            check(v[27] ? "R6 idle at end" : "R2 idle at end", ctrl_rd[1], 1'b0);
            check("R8 flag set", done_flag, 1'b1);
            check(v[26] ? "R5 hi" : "R4 hi", res_hi, v[15:8]);
            check(v[26] ? "R5 lo R3" : "R4 lo R3", res_lo, v[7:0]);
            check("R1 channel field", {ctrl_rd[3:2], chan_sel}, {2'(i), 2'(i)});
            repeat (3) @(negedge clk);
            check("R8 flag sticky", done_flag, 1'b1);
            wr(1'b1, 8'h00);
            check("R8 flag cleared", done_flag, 1'b0);
        end

        // R1 reserved bits
        wr(1'b0, 8'hF1);
        check("R1 reserved read 0", ctrl_rd, 8'hC1);
        check("R1 reference out", ref_ext, 1'b1);

        // R7 go with enable 0
        wr(1'b0, 8'h02);
        check("R7 no start when disabled", ctrl_rd[1], 1'b0);
        @(negedge clk);
        check("R7 no flag when disabled", done_flag, 1'b0);

        // R7 go while busy
        clk_is_rc = 1'b0; analog = 10'h2A5;
        wr(1'b0, 8'h83);
        repeat (2) @(negedge clk);
        wr(1'b0, 8'h83);
        repeat (5) @(negedge clk);
        check("R7 still busy", ctrl_rd[1], 1'b1);
        @(negedge clk);
        check("R7 no restart", ctrl_rd[1], 1'b0);
        check("R7 result", {res_hi, res_lo}, 16'h02A5);
        wr(1'b1, 8'h00);

        // R7 disable mid-conversion
        analog = 10'h155;
        wr(1'b0, 8'h83);
        repeat (2) @(negedge clk);
        wr(1'b0, 8'h80);
        @(negedge clk);
        check("R7 stopped by disable", ctrl_rd[1], 1'b0);
        repeat (10) @(negedge clk);
        check("R7 no flag after disable", done_flag, 1'b0);
        check("R7 result unchanged", res_lo, 8'hA5);

        // R9 RC sleep with interrupt
        clk_is_rc = 1'b1; irq_en = 1'b1; analog = 10'h0FF;
        wr(1'b0, 8'h83);
        sleep_req = 1'b1;
        repeat (13) @(negedge clk);
        check("R9 no early wake", wake, 1'b0);
        @(negedge clk);
        check("R9 wake pulse", wake, 1'b1);
        check("R9 completed", {ctrl_rd[1], done_flag, res_lo}, {2'b01, 8'hFF});
        check("R9 stays powered", conv_on, 1'b1);
        @(negedge clk);
        check("R9 wake one cycle", wake, 1'b0);
        sleep_req = 1'b0;
        wr(1'b1, 8'h00);

        // R10 RC sleep without interrupt
        irq_en = 1'b0; analog = 10'h3FF;
        wr(1'b0, 8'h83);
        sleep_req = 1'b1;
        repeat (14) @(negedge clk);
        check("R10 completed", {ctrl_rd[1], done_flag, res_hi, res_lo}, {2'b01, 16'h03FF});
        check("R10 powered down", conv_on, 1'b0);
        check("R10 enable reads 1", ctrl_rd[0], 1'b1);
        sleep_req = 1'b0;
        wr(1'b1, 8'h00);

        // R12 trigger ignored while down, write powers up
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
        check("R12 trig ignored", {ctrl_rd[1], timer_clr}, 2'b00);
        wr(1'b0, 8'h81);
        check("R12 write powers up", conv_on, 1'b1);

        // R11 non-RC sleep abort
        clk_is_rc = 1'b0; analog = 10'h200;
        wr(1'b0, 8'h83);
        repeat (3) @(negedge clk);
        sleep_req = 1'b1;
        @(negedge clk);
        check("R11 aborted", ctrl_rd[1], 1'b0);
        check("R11 powered down, enable 1", {conv_on, ctrl_rd[0]}, 2'b01);
        sleep_req = 1'b0;
        repeat (12) @(negedge clk);
        check("R11 no flag", done_flag, 1'b0);
        check("R11 result unchanged", {res_hi, res_lo}, 16'h03FF);

        // R13 trigger start
        wr(1'b0, 8'h81);
        analog = 10'h155;
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
        check("R13 trig starts", ctrl_rd[1], 1'b1);
        check("R13 timer clear", timer_clr, 1'b1);
        check("R3 first trial", dac_code, 10'h200);
        @(negedge clk);
        check("R13 timer clear one cycle", timer_clr, 1'b0);
        check("R3 second trial", dac_code, 10'h100);
        repeat (8) @(negedge clk);
        check("R13 busy before end", ctrl_rd[1], 1'b1);
        @(negedge clk);
        check("R13 done", {ctrl_rd[1], done_flag}, 2'b01);
        check("R13 R3 result", {res_hi, res_lo}, 16'h0155);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule